// File: doc/BRIEF.md
# Strobed PCM Serial Port

This block is the digital serial side of a voice codec, using a strobed single-slot format. A bit clock, a framing strobe and a data line arrive from outside. All three are brought into one system clock domain, and edge pulses are derived there. When the strobe goes high it opens one 8-bit timeslot for each frame. In that slot, one companded transmit byte is shifted out on the serial output and one companded receive byte is captured from the serial input. Both directions always share the slot that the strobe marks. There is only one channel.

Each direction has its own mute input. A muted direction carries the negative-zero quiet code instead of real data. A law-select input chooses the value of that code. A mode flag covers slow bit clocks that need a master clock. In that mode the receive sample point is placed a fixed number of master-clock cycles after each rising bit-clock edge, and the falling edge is not used. A strobe that stays high for too few or too many bit clocks causes a one-cycle framing-error pulse.

Top module: `ssi_pcm_port`

## Requirements
- R1: While reset is held, and after its release until a slot opens, `dout_oe`, `rx_valid` and `frame_err` are low.
- R2: A slot opens at the first rising bit-clock edge that finds the strobe high after a rising edge that found it low. `tx_data` is captured at that edge, and later changes to `tx_data` do not affect the byte being sent.
- R3: Inside the slot, `dout_oe` is high and the byte goes out MSB first, one bit for each rising bit-clock edge. `dout_oe` returns low at the first rising edge that finds the strobe low.
- R4: With `tx_mute` high at slot open, the quiet code is sent instead of `tx_data`. The code is 8'h7F when `law_sel`=0 (mu-law) and 8'h55 when `law_sel`=1 (A-law).
- R5: With `use_mclk`=0, `din` is sampled on falling bit-clock edges inside the slot. After the eighth sample, `rx_valid` pulses for exactly one cycle and `rx_data` holds the byte, with the first sampled bit as the MSB.
- R6: With `rx_mute` high when the byte completes, `rx_data` is the quiet code for the current `law_sel` instead of the received byte.
- R7: With `use_mclk`=1, `din` is sampled `SAMPLE_DLY` system-clock cycles after each rising bit-clock edge of the slot, and changes of `din` at falling edges have no effect.
- R8: A strobe that stays high for fewer than 8 rising edges produces no `rx_valid`. It produces a one-cycle `frame_err` pulse when the slot closes.
- R9: A strobe that stays high past 8 rising edges delivers the full received byte. At the ninth rising edge it raises a one-cycle `frame_err` and drops `dout_oe`. No new slot opens until the strobe has been seen low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System / master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | Serial bit clock, asynchronous |
| strobe | input | 1 | Active-high slot strobe |
| din | input | 1 | Serial receive data |
| dout | output | 1 | Serial transmit data |
| dout_oe | output | 1 | Output enable for `dout`, high inside the slot |
| tx_data | input | 8 | Transmit PCM byte |
| tx_mute | input | 1 | Replace transmit byte with quiet code |
| rx_mute | input | 1 | Replace received byte with quiet code |
| law_sel | input | 1 | 0 = mu-law, 1 = A-law quiet code |
| use_mclk | input | 1 | 1 = slow bit clock, sample timed by master clock |
| rx_data | output | 8 | Received PCM byte |
| rx_valid | output | 1 | One-cycle pulse: `rx_data` is new |
| frame_err | output | 1 | One-cycle pulse: strobe length was not 8 bits |

## Verification
Some properties are checked on every cycle. `rx_valid` and `frame_err` are single-cycle pulses and never coincide. A muted byte reaching `rx_data` always equals the law's quiet code. An error always leaves the output disabled. The first bit driven when the slot opens is the MSB of the byte chosen at that edge. Other behaviour shows only in the bench scenarios: the full MSB-first bit order, the choice of sample edge in each clock mode, the short- and long-strobe cases, and recovery after an error.

// File: rtl/ssi_pkg.sv
package ssi_pkg;

  localparam int SLOT_BITS = 8;

  localparam logic [SLOT_BITS-1:0] QUIET_MU = 8'h7F;
  localparam logic [SLOT_BITS-1:0] QUIET_A  = 8'h55;

  typedef enum logic [1:0] {
    SLOT_IDLE = 2'd0,
    SLOT_RUN  = 2'd1,
    SLOT_HOLD = 2'd2
  } slot_state_t;

  function automatic logic [SLOT_BITS-1:0] quiet_code(input logic law_a);
    return law_a ? QUIET_A : QUIET_MU;
  endfunction

endpackage

// File: rtl/ssi_in_sync.sv
module ssi_in_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/ssi_slot_fsm.sv
module ssi_slot_fsm
  import ssi_pkg::*;
#(
  parameter int BITS = SLOT_BITS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_rise,
  input  logic strb,
  output logic slot_start,
  output logic bit_edge,
  output logic slot_active,
  output logic frame_err
);

  localparam int CNT_W = $clog2(BITS + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BITS);

  slot_state_t      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             err_q, err_d;

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    err_d      = 1'b0;
    slot_start = 1'b0;
    bit_edge   = 1'b0;
    if (bclk_rise) begin
      unique case (state_q)
        SLOT_IDLE: begin
          if (strb) begin
            state_d    = SLOT_RUN;
            cnt_d      = CNT_W'(1);
            slot_start = 1'b1;
            bit_edge   = 1'b1;
          end
        end
        SLOT_RUN: begin
          if (strb) begin
            if (cnt_q == CNT_FULL) begin
              err_d   = 1'b1;
              state_d = SLOT_HOLD;
            end else begin
              cnt_d    = cnt_q + CNT_W'(1);
              bit_edge = 1'b1;
            end
          end else begin
            err_d   = (cnt_q != CNT_FULL);
            state_d = SLOT_IDLE;
          end
        end
        SLOT_HOLD: begin
          if (!strb) state_d = SLOT_IDLE;
        end
        default: state_d = SLOT_HOLD;
      endcase
    end
  end

  // Reset lands in HOLD so a strobe already high at release is not taken
  // as a slot opening.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SLOT_HOLD;
      cnt_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      err_q   <= err_d;
    end
  end

  assign slot_active = (state_q == SLOT_RUN);
  assign frame_err   = err_q;

endmodule

// File: rtl/ssi_tx_shifter.sv
module ssi_tx_shifter
  import ssi_pkg::*;
#(
  parameter int BITS = SLOT_BITS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            slot_start,
  input  logic            bit_edge,
  input  logic [BITS-1:0] tx_data,
  input  logic            tx_mute,
  input  logic            law_sel,
  output logic            dout
);

  logic [BITS-1:0] sh_q, sh_d;
  logic            load_en, shift_en;

  assign load_en  = slot_start;
  assign shift_en = bit_edge & ~slot_start;

  always_comb begin
    sh_d = sh_q;
    if (load_en)       sh_d = tx_mute ? quiet_code(law_sel) : tx_data;
    else if (shift_en) sh_d = {sh_q[BITS-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   sh_q <= '0;
    else if (load_en | shift_en)  sh_q <= sh_d;
  end

  assign dout = sh_q[BITS-1];

endmodule

// File: rtl/ssi_rx_shifter.sv
module ssi_rx_shifter
  import ssi_pkg::*;
#(
  parameter int BITS       = SLOT_BITS,
  parameter int SAMPLE_DLY = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            use_mclk,
  input  logic            bclk_fall,
  input  logic            bit_edge,
  input  logic            slot_start,
  input  logic            slot_active,
  input  logic            din,
  input  logic            rx_mute,
  input  logic            law_sel,
  output logic [BITS-1:0] rx_data,
  output logic            rx_valid
);

  localparam int DLY_W = (SAMPLE_DLY > 1) ? $clog2(SAMPLE_DLY) : 1;
  localparam int CNT_W = $clog2(BITS + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BITS - 1);

  logic [DLY_W-1:0] dly_q, dly_d;
  logic             run_q, run_d;
  logic             slow_tick, sample;

  logic [BITS-1:0]  sh_q, sh_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [BITS-1:0]  data_q, data_d;
  logic             valid_q, valid_d;
  logic [BITS-1:0]  shifted;

  // Master-clock sample timer: fires SAMPLE_DLY cycles after a bit edge.
  assign slow_tick = run_q & (dly_q == '0);

  always_comb begin
    dly_d = dly_q;
    run_d = run_q;
    if (bit_edge) begin
      dly_d = DLY_W'(SAMPLE_DLY - 1);
      run_d = 1'b1;
    end else if (run_q) begin
      if (dly_q == '0) run_d = 1'b0;
      else             dly_d = dly_q - DLY_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q <= '0;
      run_q <= 1'b0;
    end else begin
      dly_q <= dly_d;
      run_q <= run_d;
    end
  end

  assign sample  = slot_active & (use_mclk ? slow_tick : bclk_fall);
  assign shifted = {sh_q[BITS-2:0], din};

  always_comb begin
    sh_d    = sh_q;
    cnt_d   = cnt_q;
    data_d  = data_q;
    valid_d = 1'b0;
    if (slot_start) begin
      cnt_d = '0;
    end else if (sample && (cnt_q <= CNT_LAST)) begin
      sh_d  = shifted;
      cnt_d = cnt_q + CNT_W'(1);
      if (cnt_q == CNT_LAST) begin
        valid_d = 1'b1;
        data_d  = rx_mute ? quiet_code(law_sel) : shifted;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      cnt_q   <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      sh_q    <= sh_d;
      cnt_q   <= cnt_d;
      valid_q <= valid_d;
      if (valid_d) data_q <= data_d;
    end
  end

  assign rx_data  = data_q;
  assign rx_valid = valid_q;

endmodule

// File: rtl/ssi_pcm_port.sv
module ssi_pcm_port
  import ssi_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SAMPLE_DLY  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bclk,
  input  logic                 strobe,
  input  logic                 din,
  output logic                 dout,
  output logic                 dout_oe,
  input  logic [SLOT_BITS-1:0] tx_data,
  input  logic                 tx_mute,
  input  logic                 rx_mute,
  input  logic                 law_sel,
  input  logic                 use_mclk,
  output logic [SLOT_BITS-1:0] rx_data,
  output logic                 rx_valid,
  output logic                 frame_err
);

  localparam int SER_W = 3;

  logic [1:0]       rst_pipe_q;
  logic             rst_n_i;
  logic [SER_W-1:0] ser_sync;
  logic             bclk_s, strb_s, din_s, bclk_q;
  logic             bclk_rise, bclk_fall;
  logic             slot_start, bit_edge, slot_active;

  // Reset asserts at once and leaves on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_i = rst_pipe_q[1];

  // Bit clock, strobe and data share one synchronizer so they stay aligned.
  ssi_in_sync #(
    .STAGES (SYNC_STAGES),
    .WIDTH  (SER_W)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .async_in ({bclk, strobe, din}),
    .sync_out (ser_sync)
  );

  assign {bclk_s, strb_s, din_s} = ser_sync;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) bclk_q <= 1'b0;
    else          bclk_q <= bclk_s;
  end

  assign bclk_rise = bclk_s & ~bclk_q;
  assign bclk_fall = ~bclk_s & bclk_q;

  ssi_slot_fsm #(
    .BITS (SLOT_BITS)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n_i),
    .bclk_rise   (bclk_rise),
    .strb        (strb_s),
    .slot_start  (slot_start),
    .bit_edge    (bit_edge),
    .slot_active (slot_active),
    .frame_err   (frame_err)
  );

  ssi_tx_shifter #(
    .BITS (SLOT_BITS)
  ) u_tx (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .slot_start (slot_start),
    .bit_edge   (bit_edge),
    .tx_data    (tx_data),
    .tx_mute    (tx_mute),
    .law_sel    (law_sel),
    .dout       (dout)
  );

  ssi_rx_shifter #(
    .BITS       (SLOT_BITS),
    .SAMPLE_DLY (SAMPLE_DLY)
  ) u_rx (
    .clk         (clk),
    .rst_n       (rst_n_i),
    .use_mclk    (use_mclk),
    .bclk_fall   (bclk_fall),
    .bit_edge    (bit_edge),
    .slot_start  (slot_start),
    .slot_active (slot_active),
    .din         (din_s),
    .rx_mute     (rx_mute),
    .law_sel     (law_sel),
    .rx_data     (rx_data),
    .rx_valid    (rx_valid)
  );

  assign dout_oe = slot_active;

endmodule

// File: rtl/ssi_pcm_port_chk.sv
module ssi_pcm_port_chk
  import ssi_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 dout,
  input logic                 dout_oe,
  input logic [SLOT_BITS-1:0] tx_data,
  input logic                 tx_mute,
  input logic                 rx_mute,
  input logic                 law_sel,
  input logic [SLOT_BITS-1:0] rx_data,
  input logic                 rx_valid,
  input logic                 frame_err
);

  // R5
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R6
  rx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && $past(rx_mute)) |-> (rx_data == quiet_code($past(law_sel))));

  // R8
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err);

  // R8
  err_not_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> !rx_valid);

  // R9
  err_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> !dout_oe);

  // R2
  first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_oe) |-> (dout == ($past(tx_mute) ? quiet_code($past(law_sel)) >> 7
                                                : $past(tx_data) >> 7)));

endmodule

bind ssi_pcm_port ssi_pcm_port_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dout      (dout),
  .dout_oe   (dout_oe),
  .tx_data   (tx_data),
  .tx_mute   (tx_mute),
  .rx_mute   (rx_mute),
  .law_sel   (law_sel),
  .rx_data   (rx_data),
  .rx_valid  (rx_valid),
  .frame_err (frame_err)
);

// File: tb/ssi_pcm_port_test.sv
`timescale 1ns/1ps
module ssi_pcm_port_test;

  logic       clk, rst_n, bclk, strobe, din, dout, dout_oe;
  logic [7:0] tx_data, rx_data;
  logic       tx_mute, rx_mute, law_sel, use_mclk, rx_valid, frame_err;

  int total = 0;
  int bad   = 0;
  int err_seen = 0;
  logic [7:0] rx_q [$];

  ssi_pcm_port uut (
    .clk (clk), .rst_n (rst_n), .bclk (bclk), .strobe (strobe), .din (din),
    .dout (dout), .dout_oe (dout_oe), .tx_data (tx_data), .tx_mute (tx_mute),
    .rx_mute (rx_mute), .law_sel (law_sel), .use_mclk (use_mclk),
    .rx_data (rx_data), .rx_valid (rx_valid), .frame_err (frame_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [7:0] quiet(input logic a);
    return a ? 8'h55 : 8'h7F;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_cyc(input logic s, input logic d, input int half,
                         input logic flip, output logic oe_s, output logic do_s);
    bclk = 1'b1; strobe = s; din = d;
    wait_clk(half);
    oe_s = dout_oe; do_s = dout;
    bclk = 1'b0;
    if (flip) din = ~d;
    wait_clk(half);
  endtask

  // Monitor: pops expected receive bytes, counts error pulses.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rx_valid) begin
        if (rx_q.size() == 0) check(1'b0, "R8 unexpected rx_valid", rx_data, 0);
        else begin
          logic [7:0] e;
          e = rx_q.pop_front();
          check(rx_data == e, "R5/R6 rx byte", rx_data, e);
        end
      end
      if (rst_n && frame_err) err_seen++;
    end
  end

  task automatic frame(input logic [7:0] tx, input logic [7:0] rxb, input int nbits,
                       input logic txm, input logic rxm, input logic law,
                       input logic slow, input string req);
    int half;
    int err0;
    logic oe_s, do_s;
    logic [7:0] exp_tx;
    half = slow ? 24 : 8;
    use_mclk = slow; tx_data = tx; tx_mute = txm; rx_mute = rxm; law_sel = law;
    bit_cyc(1'b0, 1'b0, half, 1'b0, oe_s, do_s);
    bit_cyc(1'b0, 1'b0, half, 1'b0, oe_s, do_s);
    exp_tx = txm ? quiet(law) : tx;
    if (nbits >= 8) rx_q.push_back(rxm ? quiet(law) : rxb);
    err0 = err_seen;
    for (int i = 0; i < nbits; i++) begin
      bit_cyc(1'b1, (i < 8) ? rxb[7-i] : 1'b0, half, slow, oe_s, do_s);
      if (i < 8) check(oe_s && (do_s == exp_tx[7-i]), req, {oe_s, do_s}, {1'b1, exp_tx[7-i]});
      else       check(!oe_s, "R9 oe after overlong strobe", oe_s, 0);
      if (i == 0) tx_data = ~tx;
    end
    bit_cyc(1'b0, 1'b0, half, 1'b0, oe_s, do_s);
    check(!oe_s, "R3 oe low after slot", oe_s, 0);
    wait_clk(6);
    check((err_seen - err0) == ((nbits != 8) ? 1 : 0), "R8/R9 frame_err count",
          err_seen - err0, (nbits != 8) ? 1 : 0);
  endtask

  bit done = 0;
  initial begin
    #(150000 * 5);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic oe_s, do_s;
    rst_n = 1'b0; bclk = 0; strobe = 0; din = 0; tx_data = 0;
    tx_mute = 0; rx_mute = 0; law_sel = 0; use_mclk = 0;
    wait_clk(5);
    check(!dout_oe && !rx_valid && !frame_err, "R1 in reset", {dout_oe, rx_valid, frame_err}, 0);
    rst_n = 1'b1;
    wait_clk(6);
    check(!dout_oe && !rx_valid && !frame_err, "R1 after reset", {dout_oe, rx_valid, frame_err}, 0);

    frame(8'hA5, 8'h3C, 8, 0, 0, 0, 0, "R2 R3 tx latched MSB first");
    frame(8'h12, 8'hC3, 8, 1, 0, 0, 0, "R4 mu-law tx quiet");
    frame(8'h9E, 8'hF0, 8, 1, 1, 1, 0, "R4 A-law tx quiet");
    frame(8'h00, 8'h81, 8, 0, 1, 0, 0, "R6 rx mute mu-law");
    frame(8'hFF, 8'h00, 8, 0, 0, 1, 0, "R5 all-ones tx");
    frame(8'h5A, 8'h6B, 5, 0, 0, 0, 0, "R8 short strobe");
    frame(8'hC7, 8'hD2, 10, 0, 0, 0, 0, "R9 long strobe");
    frame(8'h3E, 8'hFF, 8, 0, 0, 0, 0, "R9 recovery");
    frame(8'hB4, 8'h96, 8, 0, 0, 0, 1, "R7 slow mode");
    frame(8'h21, 8'h4D, 8, 1, 1, 1, 1, "R7 slow mode muted");
    bit_cyc(1'b0, 1'b0, 8, 1'b0, oe_s, do_s);
    wait_clk(10);
    check(rx_q.size() == 0, "R5 all rx bytes delivered", rx_q.size(), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule